// File: doc/BRIEF.md
# Circular Instruction Prefetch Buffer

This block sits between a two-stage pipelined instruction memory port and an instruction decoder. It holds a sliding window of up to 32 words of 32 bits, kept in a ring of slots. Words are stored as raw 32-bit units and do not follow instruction boundaries. Two word-address counters bound the window. The look-back counter marks the oldest word that can still be used. The look-ahead counter marks the newest word for which a memory request has been issued. The block issues sequential word requests on its own, and it writes each returned word into the slot chosen by the low bits of that word's address.

The decoder presents a halfword program counter and an instruction length of 1 to 3 halfwords. In the same cycle it receives those halfwords from the ring, or a wait indication when any of them has not yet arrived. Prefetch runs at most eight words ahead of the PC's word. It also pauses when the core signals that a memory access or a possible branch is coming next, or that a memory access is executing. When the core redirects to a target outside the window, the block empties the window, drops the responses still in flight, and restarts from the target.

Top module: `ifetch_ring`

## Requirements
- R1: After reset the window is empty and the look-ahead sits one word below address 0. A decoder request waits, and the first prefetch request carries byte address 0.
- R2: Each prefetch request carries the byte address 4 above the previous one, or the redirect target word after a flush. The memory returns each request's data with `rsp_valid_i` exactly two cycles after it, so at most two requests are in flight.
- R3: No request is issued while the newest requested word is 8 or more words above the PC's word (`pc_hw_i >> 1`). Requests resume as soon as the PC advances.
- R4: A returned word goes to slot `addr[6:2]`. The decoder reads halfword slots selected by `pc_hw_i[5:0]`, wrapping modulo 64. Within a word, the lower-addressed halfword is data bits 15:0. `insn_o[16k+15:16k]` carries the halfword at `pc_hw_i + k`.
- R5: A halfword counts as present only when its word lies between the look-back word and the newest returned word. A word still in flight is not present.
- R6: `wait_o` is high exactly when `need_i` is high and any of the first `len_i` halfwords (1, 2 or 3) is not present.
- R7: When a word is written into a full ring, it replaces the oldest word. The look-back advances by one word (4 bytes) and the replaced word is no longer served. Otherwise the look-back holds.
- R8: A request is held off while `nxt_mem_i` is high, or while `nxt_br_i` is high. The exception is a branch flagged short-forward (`nxt_br_short_i`) whose target word `nxt_br_tgt_i` is present; that branch does not hold off requests.
- R9: No request is issued while `mem_exec_i` is high.
- R10: A redirect whose target word lies outside the span from look-back to look-ahead empties the window, discards responses still in flight, and restarts requests at the target word. A redirect inside the span keeps all contents and issues no request of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_hw_i | input | 31 | Halfword address of the instruction being decoded |
| len_i | input | 2 | Instruction length in halfwords (1 to 3) |
| need_i | input | 1 | Decoder wants the instruction at `pc_hw_i` this cycle |
| redirect_i | input | 1 | `pc_hw_i` is a branch target this cycle |
| nxt_mem_i | input | 1 | Next instruction accesses memory or I/O |
| nxt_br_i | input | 1 | Next instruction may branch |
| nxt_br_short_i | input | 1 | That branch is a one-halfword forward branch |
| nxt_br_tgt_i | input | 30 | Word address of that branch's target |
| mem_exec_i | input | 1 | A memory or I/O instruction is executing |
| req_o | output | 1 | Prefetch request this cycle |
| req_addr_o | output | 32 | Byte address of the requested word |
| rsp_valid_i | input | 1 | Data for the request from two cycles earlier |
| rsp_data_i | input | 32 | Returned instruction word |
| insn_o | output | 48 | Up to three halfwords starting at the PC |
| wait_o | output | 1 | Decoder must stall |

## Verification
On every cycle the assertions check the counter bookkeeping. The span from look-back to look-ahead always equals the stored words plus the live requests in flight. The look-ahead steps by one word per request. The look-back moves only on a replacement, and only when the written slot is the one it points at. A flush leaves an empty window based at the target, and requests never coincide with an executing memory instruction. Data placement, the modulo-64 halfword wrap, the exact wait latency after reset and after a flush, and the dropping of stale responses can only be shown through the bench's scenarios. These include a march of the PC across more than two laps of the ring and redirects inside and outside the window.

// File: rtl/ifr_pkg.sv
`timescale 1ns/1ps
package ifr_pkg;
  localparam int unsigned IFR_AW = 32;
  localparam int unsigned IFR_WA = IFR_AW - 2;

  typedef logic [IFR_WA-1:0] word_t;

  typedef struct packed {
    logic  live;
    word_t addr;
  } pend_t;

  // word w falls within [base, base+cnt)
  function automatic logic span_has(word_t w, word_t base, word_t cnt);
    word_t off;
    off = w - base;
    return off < cnt;
  endfunction

  // prefetch may continue while newest request is less than lead words past pc
  function automatic logic lead_open(word_t la, word_t pcw, int unsigned lead);
    word_t d;
    int    sd;
    d  = la - pcw;
    sd = int'($signed(d));
    return sd < int'(lead);
  endfunction
endpackage

// File: rtl/ifr_store.sv
`timescale 1ns/1ps
module ifr_store
  import ifr_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned PORTS = 3,
  parameter int unsigned SW    = $clog2(SLOTS),
  parameter int unsigned HI_W  = $clog2(2 * SLOTS)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [SW-1:0]              wr_slot,
  input  logic [31:0]                wr_data,
  input  logic [PORTS-1:0][HI_W-1:0] rd_hidx,
  output logic [PORTS-1:0][15:0]     rd_half
);
  logic [31:0] ring [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) ring[wr_slot] <= wr_data;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    logic [31:0] word_q;
    assign word_q     = ring[rd_hidx[p][HI_W-1:1]];
    assign rd_half[p] = rd_hidx[p][0] ? word_q[31:16] : word_q[15:0];
  end
endmodule

// File: rtl/ifr_window.sv
`timescale 1ns/1ps
module ifr_window
  import ifr_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned OCC_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  word_t            flush_w,
  input  logic             issue,
  input  logic             wr_en,
  output word_t            lb_w,
  output word_t            la_w,
  output logic [OCC_W-1:0] occ,
  output logic             evict
);
  assign evict = wr_en && (occ == OCC_W'(SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_w <= '0;
      la_w <= '1;
      occ  <= '0;
    end else if (flush) begin
      lb_w <= flush_w;
      la_w <= flush_w - word_t'(1);
      occ  <= '0;
    end else begin
      if (issue) la_w <= la_w + word_t'(1);
      if (evict) lb_w <= lb_w + word_t'(1);
      else if (wr_en) occ <= occ + OCC_W'(1);
    end
  end
endmodule

// File: rtl/ifr_issue.sv
`timescale 1ns/1ps
module ifr_issue
  import ifr_pkg::*;
#(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned LIVE_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  word_t             issue_w,
  input  logic              flush,
  input  logic              rsp_valid,
  output logic              wr_en,
  output word_t             wr_w,
  output logic [LIVE_W-1:0] n_live
);
  pend_t [DEPTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0].live <= issue;
      stg[0].addr <= issue_w;
      for (int k = 1; k < DEPTH; k++) begin
        stg[k].live <= stg[k-1].live & ~flush;
        stg[k].addr <= stg[k-1].addr;
      end
    end
  end

  assign wr_en = stg[DEPTH-1].live & rsp_valid & ~flush;
  assign wr_w  = stg[DEPTH-1].addr;

  always_comb begin
    n_live = '0;
    for (int k = 0; k < DEPTH; k++) n_live = n_live + LIVE_W'(stg[k].live);
  end
endmodule

// File: rtl/ifetch_ring.sv
`timescale 1ns/1ps
module ifetch_ring
  import ifr_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned LEAD   = 8,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned MAXLEN = 3,
  localparam int unsigned LEN_W = $clog2(MAXLEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IFR_AW-2:0]     pc_hw_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic                  need_i,
  input  logic                  redirect_i,
  input  logic                  nxt_mem_i,
  input  logic                  nxt_br_i,
  input  logic                  nxt_br_short_i,
  input  logic [IFR_WA-1:0]     nxt_br_tgt_i,
  input  logic                  mem_exec_i,
  output logic                  req_o,
  output logic [IFR_AW-1:0]     req_addr_o,
  input  logic                  rsp_valid_i,
  input  logic [31:0]           rsp_data_i,
  output logic [16*MAXLEN-1:0]  insn_o,
  output logic                  wait_o
);
  localparam int unsigned SW     = $clog2(SLOTS);
  localparam int unsigned HI_W   = $clog2(2 * SLOTS);
  localparam int unsigned OCC_W  = $clog2(SLOTS + 1);
  localparam int unsigned LIVE_W = $clog2(DEPTH + 1);
  localparam int unsigned HW_W   = IFR_AW - 1;

  word_t             pc_w;
  word_t             lb_w;
  word_t             la_w;
  word_t             wr_w;
  word_t             span;
  logic [OCC_W-1:0]  occ;
  logic [LIVE_W-1:0] n_live;
  logic              evict;
  logic              wr_en;
  logic              flush;
  logic              issue;
  logic              tgt_ok;
  logic              hold_next;
  logic              lead_ok;

  assign pc_w = pc_hw_i[HW_W-1:1];
  assign span = la_w - lb_w + word_t'(1);

  // control events
  assign flush     = redirect_i & ~span_has(pc_w, lb_w, span);
  assign tgt_ok    = span_has(nxt_br_tgt_i, lb_w, word_t'(occ));
  assign hold_next = nxt_mem_i | (nxt_br_i & ~(nxt_br_short_i & tgt_ok));
  assign lead_ok   = lead_open(la_w, pc_w, LEAD);
  assign issue     = lead_ok & ~hold_next & ~mem_exec_i & ~flush;

  assign req_o      = issue;
  assign req_addr_o = {la_w + word_t'(1), 2'b00};

  ifr_window #(.SLOTS(SLOTS), .OCC_W(OCC_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .flush_w (pc_w),
    .issue   (issue),
    .wr_en   (wr_en),
    .lb_w    (lb_w),
    .la_w    (la_w),
    .occ     (occ),
    .evict   (evict)
  );

  ifr_issue #(.DEPTH(DEPTH), .LIVE_W(LIVE_W)) u_iss (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .issue_w   (la_w + word_t'(1)),
    .flush     (flush),
    .rsp_valid (rsp_valid_i),
    .wr_en     (wr_en),
    .wr_w      (wr_w),
    .n_live    (n_live)
  );

  // read side
  logic [MAXLEN-1:0][HI_W-1:0] hidx;
  logic [MAXLEN-1:0][15:0]     half;
  logic [MAXLEN-1:0]           have;
  logic [MAXLEN-1:0]           want;

  for (genvar k = 0; k < MAXLEN; k++) begin : g_hw
    logic [HW_W-1:0] h_k;
    assign h_k     = pc_hw_i + HW_W'(k);
    assign hidx[k] = h_k[HI_W-1:0];
    assign have[k] = span_has(h_k[HW_W-1:1], lb_w, word_t'(occ));
    assign want[k] = LEN_W'(k) < len_i;
    assign insn_o[16*k +: 16] = half[k];
  end

  ifr_store #(.SLOTS(SLOTS), .PORTS(MAXLEN), .SW(SW), .HI_W(HI_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_slot (wr_w[SW-1:0]),
    .wr_data (rsp_data_i),
    .rd_hidx (hidx),
    .rd_half (half)
  );

  assign wait_o = need_i & |(want & ~have);
endmodule

// File: rtl/ifr_chk.sv
`timescale 1ns/1ps
module ifr_chk
  import ifr_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned OCC_W  = $clog2(SLOTS + 1),
  parameter int unsigned LIVE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_o,
  input logic              mem_exec_i,
  input logic              rsp_valid_i,
  input logic              flush,
  input logic              evict,
  input logic              wr_en,
  input word_t             wr_w,
  input word_t             lb_w,
  input word_t             la_w,
  input word_t             pc_w,
  input logic [OCC_W-1:0]  occ,
  input logic [LIVE_W-1:0] n_live
);
  localparam int unsigned SW = $clog2(SLOTS);

  word_t span_q;
  word_t held_q;
  assign span_q = la_w - lb_w + word_t'(1);
  assign held_q = word_t'(occ) + word_t'(n_live);

  // R2
  span_acct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span_q == held_q);

  // R2
  la_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> la_w == $past(la_w) + word_t'(1));

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_i |-> $past(req_o, 2));

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(SLOTS));

  // R7
  evict_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (wr_en && wr_w[SW-1:0] == lb_w[SW-1:0]));

  // R7
  lb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> lb_w == $past(lb_w) + word_t'(1));

  // R7
  lb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evict && !flush) |=> lb_w == $past(lb_w));

  // R9
  exec_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_exec_i |-> !req_o);

  // R10
  flush_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0 && n_live == '0 && lb_w == $past(pc_w)));
endmodule

bind ifetch_ring ifr_chk #(.SLOTS(SLOTS), .OCC_W(OCC_W), .LIVE_W(LIVE_W)) u_chk (.*);

// File: tb/sim_ifetch_ring.sv
`timescale 1ns/1ps
module sim_ifetch_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] pc_hw = '0;
  logic [1:0]  len = 2'd1;
  logic        need = 1'b1;
  logic        redirect = 1'b0;
  logic        nmem = 1'b0, nbr = 1'b0, nshort = 1'b0, mexec = 1'b0;
  logic [29:0] ntgt = '0;
  logic        req;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [47:0] insn;
  logic        wt;

  int n_chk = 0;
  int n_err = 0;
  int n_req = 0;
  logic [31:0] exp_req = '0;

  always #5 clk = ~clk;

  function automatic logic [15:0] hv(int h);
    return 16'(h * 7 + 'h0F31);
  endfunction

  function automatic logic [31:0] wv(int w);
    return {hv(2 * w + 1), hv(2 * w)};
  endfunction

  // memory: data two cycles after request
  logic        q0v, q1v;
  logic [31:0] q0a, q1a;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0v <= 1'b0; q1v <= 1'b0; q0a <= '0; q1a <= '0;
    end else begin
      q0v <= req; q0a <= req_addr;
      q1v <= q0v; q1a <= q0a;
    end
  end
  assign rsp_valid = q1v;
  assign rsp_data  = wv(int'(q1a >> 2));

  ifetch_ring u0 (
    .clk(clk), .rst_n(rst_n), .pc_hw_i(pc_hw), .len_i(len), .need_i(need),
    .redirect_i(redirect), .nxt_mem_i(nmem), .nxt_br_i(nbr),
    .nxt_br_short_i(nshort), .nxt_br_tgt_i(ntgt), .mem_exec_i(mexec),
    .req_o(req), .req_addr_o(req_addr), .rsp_valid_i(rsp_valid),
    .rsp_data_i(rsp_data), .insn_o(insn), .wait_o(wt)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mask_of(int l);
    return (l == 1) ? 48'h0000_0000_FFFF : (l == 2) ? 48'h0000_FFFF_FFFF : 48'hFFFF_FFFF_FFFF;
  endfunction

  function automatic logic [47:0] exp_insn(int h, int l);
    logic [47:0] e = '0;
    for (int k = 0; k < l; k++) e[16*k +: 16] = hv(h + k);
    return e;
  endfunction

  // request monitor, sampled just before each rising edge (R2)
  always @(negedge clk) begin
    #4;
    if (rst_n && req) begin
      n_req++;
      chk(req_addr == exp_req, "R2 request address", 64'(req_addr), 64'(exp_req));
      exp_req = exp_req + 32'd4;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_at(int h, int l, string tag);
    int tries = 0;
    @(negedge clk);
    pc_hw = 31'(h); len = 2'(l);
    #1;
    while (wt && tries < 12) begin
      @(negedge clk); #1; tries++;
    end
    chk(!wt, {tag, " wait cleared"}, 64'(wt), 64'd0);
    chk((insn & mask_of(l)) == exp_insn(h, l), tag, 64'(insn & mask_of(l)), 64'(exp_insn(h, l)));
  endtask

  initial begin
    int cnt0;
    int h;
    int l;
    cyc(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req == 1'b1, "R1 first request", 64'(req), 64'd1);
    chk(req_addr == 32'd0, "R1 first address", 64'(req_addr), 64'd0);
    chk(wt == 1'b1, "R1 empty window waits", 64'(wt), 64'd1);
    // R5 in-flight words are not present
    @(negedge clk); #1;
    chk(wt == 1'b1, "R5 word 0 in flight (1)", 64'(wt), 64'd1);
    @(negedge clk); #1;
    chk(wt == 1'b1, "R5 word 0 in flight (2)", 64'(wt), 64'd1);
    @(negedge clk); #1;
    chk(wt == 1'b0, "R5 word 0 stored", 64'(wt), 64'd0);
    chk(insn[15:0] == hv(0), "R4 first halfword", 64'(insn[15:0]), 64'(hv(0)));
    cyc(10);
    // R3 lead limit: words 0..8 requested
    chk(n_req == 9, "R3 lead stop count", 64'(n_req), 64'd9);
    chk(exp_req == 32'd36, "R3 last address+4", 64'(exp_req), 64'd36);
    // R6 variable length presence
    pc_hw = 31'd17; len = 2'd1; #1;
    chk(wt == 1'b0, "R6 len1 at word 8", 64'(wt), 64'd0);
    len = 2'd2; #1;
    chk(wt == 1'b1, "R6 len2 reaches word 9", 64'(wt), 64'd1);
    need = 1'b0; #1;
    chk(wt == 1'b0, "R6 no need no wait", 64'(wt), 64'd0);
    need = 1'b1; pc_hw = 31'd0; len = 2'd1;
    // R3 resume after pc moves two words
    @(negedge clk); pc_hw = 31'd4;
    cyc(8);
    chk(n_req == 11, "R3 resume count", 64'(n_req), 64'd11);
    // R4 sweep of start halfword and length inside the window
    for (int hh = 0; hh <= 21; hh++)
      for (int ll = 1; ll <= 3; ll++)
        if (hh + ll - 1 <= 21) read_at(hh, ll, "R4 sweep");
    // R4 R7 march across two ring laps
    h = 21; l = 1;
    while (h < 120) begin
      read_at(h, l, "R4 march");
      h = h + l;
      l = (l == 3) ? 1 : l + 1;
    end
    @(negedge clk); pc_hw = 31'd120; len = 2'd1;
    cyc(8);
    // window now holds words 37..68
    pc_hw = 31'd74; #1;
    chk(wt == 1'b0, "R7 oldest kept word", 64'(wt), 64'd0);
    pc_hw = 31'd73; #1;
    chk(wt == 1'b1, "R7 replaced word gone", 64'(wt), 64'd1);
    // R10 redirect inside window
    cnt0 = n_req;
    pc_hw = 31'd74; redirect = 1'b1; #1;
    chk(wt == 1'b0, "R10 inside target present", 64'(wt), 64'd0);
    @(negedge clk); redirect = 1'b0; #1;
    chk(wt == 1'b0, "R10 inside kept", 64'(wt), 64'd0);
    chk(insn[15:0] == hv(74), "R10 inside data", 64'(insn[15:0]), 64'(hv(74)));
    chk(n_req == cnt0, "R10 inside no request", 64'(n_req), 64'(cnt0));
    pc_hw = 31'd120;
    cyc(3);
    // R10 outside redirect with a request in flight
    pc_hw = 31'd124;
    @(negedge clk);
    pc_hw = 31'd72; redirect = 1'b1; exp_req = 32'd144; #1;
    chk(wt == 1'b1, "R10 outside target absent", 64'(wt), 64'd1);
    @(negedge clk); redirect = 1'b0; #1;
    chk(wt == 1'b1, "R10 after flush", 64'(wt), 64'd1);
    @(negedge clk); #1;
    chk(wt == 1'b1, "R10 stale response dropped", 64'(wt), 64'd1);
    @(negedge clk); #1;
    chk(wt == 1'b1, "R10 target in flight", 64'(wt), 64'd1);
    @(negedge clk); #1;
    chk(wt == 1'b0, "R10 target arrived", 64'(wt), 64'd0);
    chk(insn[15:0] == hv(72), "R10 target data", 64'(insn[15:0]), 64'(hv(72)));
    cyc(8);
    // R8 R9 hold-off hints (window words 36..44)
    pc_hw = 31'd74; #0.5;
    chk(req == 1'b1, "R3 baseline request", 64'(req), 64'd1);
    nmem = 1'b1; #0.5;
    chk(req == 1'b0, "R8 next memory halts", 64'(req), 64'd0);
    nmem = 1'b0; mexec = 1'b1; #0.5;
    chk(req == 1'b0, "R9 executing memory halts", 64'(req), 64'd0);
    mexec = 1'b0; nbr = 1'b1; nshort = 1'b0; #0.5;
    chk(req == 1'b0, "R8 branch halts", 64'(req), 64'd0);
    nshort = 1'b1; ntgt = 30'd40; #0.5;
    chk(req == 1'b1, "R8 short forward present target", 64'(req), 64'd1);
    ntgt = 30'd100; #0.5;
    chk(req == 1'b0, "R8 short forward absent target", 64'(req), 64'd0);
    nbr = 1'b0; nshort = 1'b0;
    cyc(6);
    read_at(80, 3, "R4 after hints");
    cyc(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule